// File: doc/BRIEF.md
# Programmable Delay Line and Circular Buffer

This block delays a stream of data words by a number of clock cycles chosen at run time. In pipeline mode a new word is taken from the input port on every advancing cycle, and it reappears at the output a fixed number of cycles later. In recirculate mode the output word is fed back into the head of the delay path, so the words already held circulate with a period equal to the programmed length.

The delay path has three parts: an input register, a variable section and an output register. The variable section is a circular RAM with one write pointer, and its read address is derived by subtracting the programmed length from that pointer. A length of zero skips the RAM entirely, which leaves the two fixed registers as the minimum delay of two cycles. The length word is loaded through a dedicated port and strobe, and a value above the supported maximum is clamped to that maximum.

The mode select and the clock-enable hold are both registered before they act. A hold request freezes every internal register from the following cycle onward. The output enable is registered as well and only gates the output port: when it is low, `dout` reads zero and `dout_drive` is low, while data keeps moving inside the block.

Top module: `prog_delay_buf`

## Requirements
- R1: A synchronous active-high reset clears the input and output registers and the write pointer. It sets the programmed length to 0 and selects pipeline mode, and it clears the hold and the drive flag, so after reset `dout` reads 0 and `dout_drive` is 0.
- R2: In pipeline mode with no hold, a word placed on `din` in cycle c appears on `dout` in cycle c+L+2, where L is the programmed length.
- R3: A programmed length of 0 bypasses the RAM and gives the minimum total delay of 2 cycles.
- R4: `len_val` is captured on an advancing edge where `len_load` is 1, and the new delay governs the edges after that one. While `len_load` is 0, `len_val` has no effect.
- R5: A loaded value above MAX_PROG (default 1279) is stored as MAX_PROG. With the bench setting MAX_PROG=40 and LEN_W=8, a value of 41 or 200 both give a total delay of 42.
- R6: With `recirc_sel` = 1 (recirculate), the input register takes the output register's word instead of `din`, so the held words repeat on `dout` with a period of L+2 cycles.
- R7: `recirc_sel` is sampled on one advancing edge, and the source it selects is used on the following advancing edge (value 0 = external input, 1 = recirculate).
- R8: `hold_req` is sampled on every edge. When the sampled value is 1, the next edge changes neither the data registers, the pointer, the length nor the mode (a `len_load` on that edge is ignored). The stream resumes without any loss once the hold is released.
- R9: `out_en` is sampled on every edge, including held edges. While the sampled value is 0, `dout` is 0 and `dout_drive` is 0, and the internal data movement is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Data word taken in pipeline mode |
| len_val | input | LEN_W | Length word (total delay minus 2) |
| len_load | input | 1 | Strobe that loads `len_val` |
| recirc_sel | input | 1 | Source select, registered: 0 external input, 1 recirculate |
| hold_req | input | 1 | Registered request that freezes all internal state |
| out_en | input | 1 | Registered output enable |
| dout | output | DATA_W | Delayed word, or 0 when not driven |
| dout_drive | output | 1 | 1 while the output is enabled |

## Verification
The bench builds the block with DATA_W=10, LEN_W=8 and MAX_PROG=40. This shrinks the RAM to 41 words, so the maximum delay, the wrap of the write pointer and full recirculation loops all fit into a few hundred cycles. With an 8-bit length port, values above 40 can be loaded, so the clamp to 42 total cycles is exercised with both a value just past the limit and a value far past it. A queue model in the bench follows the registered mode, the hold and the output enable, and it predicts every output word across length changes, mode switches, hold bursts and a reset in the middle of a run.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

   // Source of the word entering the delay path
   typedef enum logic {
      PDB_SRC_EXT    = 1'b0,
      PDB_SRC_RECIRC = 1'b1
   } pdb_src_e;

endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
   import pdb_pkg::*;
#(
   parameter int LEN_W    = 11,
   parameter int MAX_PROG = 1279
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] len_val,
   input  logic             len_load,
   input  logic             recirc_sel,
   input  logic             hold_req,
   output logic             adv,
   output logic [LEN_W-1:0] len_q,
   output pdb_src_e         src_q
);

   typedef logic [LEN_W-1:0] len_t;

   localparam longint LEN_SPAN = 64'd1 << LEN_W;

   logic hold_q;
   len_t len_next;

   generate
      if (LEN_W < 1 || LEN_W > 31) begin : g_bad_w
         $error("pdb_ctrl: LEN_W out of range");
      end
      if (MAX_PROG < 1 || longint'(MAX_PROG) >= LEN_SPAN) begin : g_bad_max
         $error("pdb_ctrl: MAX_PROG must be at least 1 and fit in LEN_W bits");
      end
      if (longint'(MAX_PROG) < LEN_SPAN - 1) begin : g_sat
         // Port can carry values past the limit: clamp them
         always_comb begin
            if (len_val > len_t'(MAX_PROG)) len_next = len_t'(MAX_PROG);
            else                            len_next = len_val;
         end
      end else begin : g_full
         // Every encodable value is legal
         assign len_next = len_val;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= 1'b0;
         len_q  <= '0;
         src_q  <= PDB_SRC_EXT;
      end else begin
         hold_q <= hold_req;
         if (!hold_q) begin
            if (len_load) len_q <= len_next;
            src_q <= recirc_sel ? PDB_SRC_RECIRC : PDB_SRC_EXT;
         end
      end
   end

   assign adv = !hold_q;

   AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
      len_q <= len_t'(MAX_PROG)); // R5

   AST_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      (adv && !len_load) |=> $stable(len_q)); // R4

   AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(len_q) && $stable(src_q))); // R8

endmodule

// File: rtl/pdb_var_sect.sv
module pdb_var_sect #(
   parameter int DATA_W   = 10,
   parameter int LEN_W    = 11,
   parameter int MAX_PROG = 1279
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] tap
);

   localparam int DEPTH = MAX_PROG + 1;
   localparam int AW    = (DEPTH > 2) ? $clog2(DEPTH) : 1;

   typedef logic [AW-1:0] addr_t;
   typedef logic [AW:0]   ext_t;

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("pdb_var_sect: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] ram [DEPTH];
   addr_t wp, rp;
   ext_t  wp_x, len_x, rp_x;

   // Read address sits len entries behind the write pointer, modulo DEPTH
   always_comb begin
      wp_x = {1'b0, wp};
      len_x = ext_t'(len);
      if (wp_x >= len_x) rp_x = wp_x - len_x;
      else               rp_x = wp_x + ext_t'(DEPTH) - len_x;
      rp = rp_x[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp <= '0;
      end else if (adv) begin
         if (wp == addr_t'(DEPTH - 1)) wp <= '0;
         else                          wp <= wp + addr_t'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (adv) ram[wp] <= wr_data;
   end

   // Zero length: skip the RAM, leaving only the two fixed registers
   assign tap = (len == '0) ? wr_data : ram[rp];

   AST_WP_RANGE: assert property (@(posedge clk) disable iff (rst)
      wp <= addr_t'(DEPTH - 1)); // R2

   AST_WP_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(wp)); // R8

endmodule

// File: rtl/pdb_out_stage.sv
module pdb_out_stage #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              out_en,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drive
);

   logic drive_q;

   always_ff @(posedge clk) begin
      if (rst) drive_q <= 1'b0;
      else     drive_q <= out_en;
   end

   assign dout_drive = drive_q;
   assign dout       = drive_q ? data : '0;

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      !dout_drive |-> (dout == '0)); // R9

   AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      $rose(dout_drive) |-> $past(out_en)); // R9

endmodule

// File: rtl/prog_delay_buf.sv
module prog_delay_buf
   import pdb_pkg::*;
#(
   parameter int DATA_W   = 10,
   parameter int LEN_W    = 11,
   parameter int MAX_PROG = 1279
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              len_load,
   input  logic              recirc_sel,
   input  logic              hold_req,
   input  logic              out_en,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drive
);

   logic              adv;
   logic [LEN_W-1:0]  len_q;
   pdb_src_e          src_q;
   logic [DATA_W-1:0] in_reg, out_reg, head, tap;

   pdb_ctrl #(
      .LEN_W    (LEN_W),
      .MAX_PROG (MAX_PROG)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .len_val    (len_val),
      .len_load   (len_load),
      .recirc_sel (recirc_sel),
      .hold_req   (hold_req),
      .adv        (adv),
      .len_q      (len_q),
      .src_q      (src_q)
   );

   assign head = (src_q == PDB_SRC_RECIRC) ? out_reg : din;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_reg  <= '0;
         out_reg <= '0;
      end else if (adv) begin
         in_reg  <= head;
         out_reg <= tap;
      end
   end

   pdb_var_sect #(
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W),
      .MAX_PROG (MAX_PROG)
   ) u_var (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .len     (len_q),
      .wr_data (in_reg),
      .tap     (tap)
   );

   pdb_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk        (clk),
      .rst        (rst),
      .out_en     (out_en),
      .data       (out_reg),
      .dout       (dout),
      .dout_drive (dout_drive)
   );

   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(in_reg) && $stable(out_reg))); // R8

   AST_BYPASS_TWO: assert property (@(posedge clk) disable iff (rst)
      (adv && len_q == '0) |=> (out_reg == $past(in_reg))); // R3

   AST_LOOP_CLOSE: assert property (@(posedge clk) disable iff (rst)
      (adv && src_q == PDB_SRC_RECIRC) |=> (in_reg == $past(out_reg))); // R6

endmodule

// File: tb/prog_delay_buf_bench.sv
module prog_delay_buf_bench;

   localparam int DW = 10;
   localparam int LW = 8;
   localparam int MP = 40;
   localparam int NROWS = 10;

   typedef struct packed {
      int len_in;   // value driven on len_val
      int exp_tot;  // expected total delay after the load
      int recirc;   // recirc_sel during the row
      int steps;    // cycles in the row
      int hold_per; // hold every Nth cycle, 0 = never
      int oe_per;   // toggle out_en every N cycles, 0 = always on
      int req;      // requirement number
   } row_t;

   localparam row_t ROWS [NROWS] = '{
      '{0,   2,  0, 12, 0, 0, 3},  // R3 minimum delay
      '{5,   7,  0, 20, 0, 0, 2},  // R2 / R4 load of 5
      '{5,   7,  1, 30, 0, 0, 6},  // R6 loop of 7
      '{17,  19, 0, 40, 4, 0, 8},  // R8 periodic holds
      '{200, 42, 0, 60, 0, 0, 5},  // R5 far past limit
      '{40,  42, 1, 90, 7, 0, 6},  // R6 longest loop, with holds
      '{41,  42, 0, 50, 0, 0, 5},  // R5 just past limit
      '{1,   3,  0, 24, 0, 3, 9},  // R9 output enable toggling
      '{1,   3,  1, 15, 0, 0, 6},  // R6 loop of 3
      '{0,   2,  1, 10, 0, 0, 6}   // R6 loop of 2
   };

   logic          clk = 1'b0;
   logic          rst;
   logic [DW-1:0] din;
   logic [LW-1:0] len_val;
   logic          len_load, recirc_sel, hold_req, out_en;
   logic [DW-1:0] dout;
   logic          dout_drive;

   always #10 clk = ~clk;

   prog_delay_buf #(
      .DATA_W   (DW),
      .LEN_W    (LW),
      .MAX_PROG (MP)
   ) u_prog_delay_buf (
      .clk        (clk),
      .rst        (rst),
      .din        (din),
      .len_val    (len_val),
      .len_load   (len_load),
      .recirc_sel (recirc_sel),
      .hold_req   (hold_req),
      .out_en     (out_en),
      .dout       (dout),
      .dout_drive (dout_drive)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference model state
   int ent [0:8191];
   bit entk [0:8191];
   int k_m;
   int len_m;
   bit mode_m, hold_m, drive_m;
   int out_m;
   bit outk_m;
   int gcyc = 0;

   task automatic model_reset();
      k_m = 0; len_m = 0; mode_m = 1'b0; hold_m = 1'b0; drive_m = 1'b0;
      out_m = 0; outk_m = 1'b1;
   endtask

   task automatic compare(input int req);
      n_cmp++;
      if (dout_drive !== drive_m) begin
         n_bad++;
         $display("FAIL R%0d dout_drive=%b expected %b", req, dout_drive, drive_m);
      end
      if (!drive_m || outk_m) begin
         int exp_v;
         exp_v = drive_m ? out_m : 0;
         n_cmp++;
         if (dout !== DW'(exp_v)) begin
            n_bad++;
            $display("FAIL R%0d dout=%h expected %h (cycle %0d)", req, dout, DW'(exp_v), gcyc);
         end
      end
   endtask

   task automatic step(input logic [DW-1:0] d, input logic sel, input logic hold,
                       input logic ld, input logic [LW-1:0] lv, input int lexp,
                       input logic oe, input int req);
      int  in_v, idx;
      bit  in_k;
      din = d; recirc_sel = sel; hold_req = hold; len_load = ld; len_val = lv; out_en = oe;
      @(posedge clk);
      gcyc++;
      if (!hold_m) begin
         in_v = mode_m ? out_m : int'(d);
         in_k = mode_m ? outk_m : 1'b1;
         idx = k_m - len_m - 1;
         if (idx == -1) begin
            out_m = 0; outk_m = 1'b1;
         end else if (idx < -1) begin
            outk_m = 1'b0;
         end else begin
            out_m = ent[idx]; outk_m = entk[idx];
         end
         ent[k_m] = in_v; entk[k_m] = in_k; k_m++;
         if (ld) len_m = lexp - 2;
         mode_m = sel;
      end
      hold_m = hold;
      drive_m = oe;
      @(negedge clk);
      compare(req);
   endtask

   task automatic do_reset();
      rst = 1'b1; din = '0; len_val = '0; len_load = 1'b0;
      recirc_sel = 1'b0; hold_req = 1'b0; out_en = 1'b0;
      @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 1'b0;
      // R1: cleared output and drive flag
      n_cmp++;
      if (dout !== '0 || dout_drive !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 dout=%h drive=%b expected 000 0", dout, dout_drive);
      end
   endtask

   initial begin
      rst = 1'b1;
      @(negedge clk);
      do_reset();
      // R1: default length 0, pipeline, zero contents
      for (int i = 0; i < 3; i++) step(DW'(i + 1), 1'b0, 1'b0, 1'b0, '0, 2, 1'b1, 1);

      for (int r = 0; r < NROWS; r++) begin
         for (int s = 0; s < ROWS[r].steps; s++) begin
            logic h, o, ld;
            logic [LW-1:0] lv;
            ld = (s == 0);
            lv = ld ? LW'(ROWS[r].len_in) : LW'(8'hFF); // R4: ignored without strobe
            h = (ROWS[r].hold_per != 0) && (s > 0) && (s < ROWS[r].steps - 1) &&
                (s % ROWS[r].hold_per == ROWS[r].hold_per - 1);
            o = (ROWS[r].oe_per == 0) ? 1'b1 : (((s / ROWS[r].oe_per) % 2) == 0);
            step(DW'((gcyc * 37 + r * 101 + 5) & 32'h3FF), ROWS[r].recirc[0], h, ld, lv,
                 ROWS[r].exp_tot, o, ROWS[r].req);
         end
      end

      // R7: source switch takes effect one edge after it is sampled
      for (int i = 0; i < 8; i++)
         step(DW'(10'h200 + i), (i >= 3 && i < 6), 1'b0, (i == 0), LW'(2), 4, 1'b1, 7);

      // R8: a load on a held edge is ignored; length stays 2
      step(DW'(10'h011), 1'b0, 1'b1, 1'b0, '0, 4, 1'b1, 8);
      step(DW'(10'h022), 1'b0, 1'b1, 1'b1, LW'(9), 11, 1'b1, 8);
      step(DW'(10'h033), 1'b0, 1'b0, 1'b1, LW'(9), 11, 1'b1, 8);
      for (int i = 0; i < 8; i++) step(DW'(10'h040 + i), 1'b0, 1'b0, 1'b0, '0, 4, 1'b1, 8);
      // R8 / R2: delay 4 checked explicitly, word 0x3C5 shows up 4 cycles later
      step(DW'(10'h3C5), 1'b0, 1'b0, 1'b1, LW'(2), 4, 1'b1, 2);
      for (int i = 0; i < 3; i++) step(DW'(i), 1'b0, 1'b0, 1'b0, '0, 4, 1'b1, 2);
      n_cmp++;
      if (dout !== DW'(10'h3C5)) begin
         n_bad++;
         $display("FAIL R2 dout=%h expected %h", dout, DW'(10'h3C5));
      end

      // R9: output off keeps data moving
      for (int i = 0; i < 6; i++) step(DW'(10'h100 + i), 1'b0, 1'b0, 1'b0, '0, 4, (i > 3), 9);

      // R1: reset in the middle of a run
      step(DW'(10'h155), 1'b0, 1'b0, 1'b0, '0, 4, 1'b1, 1);
      do_reset();
      for (int i = 0; i < 3; i++) step(DW'(10'h2AA), 1'b0, 1'b0, 1'b0, '0, 2, 1'b1, 1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", gcyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule